// File: doc/BRIEF.md
# Time-Multiplexed Four-Lane 8b10b Decoder

This block turns four received 10-bit line codes into bytes using only two 8b10b decode cores. Each core is shared by a pair of lanes. A new character arrives on a lane only every second system clock cycle, so one core can serve both lanes of its pair. In a given cycle the core decodes one lane of the pair, while the other lane's character waits in a buffer register.

A free-running phase bit sets the schedule. An extend input flips the phase, which moves each lane's decode slot by one cycle. Upstream alignment logic uses this to widen its word-slip range beyond what bit slipping alone can reach. Each lane reports a byte, a control flag, a code-error flag and a one-cycle valid strobe. Running disparity is tracked separately for every lane, so interleaving two lanes through one core never mixes their disparity histories.

Top module: `tdm_8b10b_rx`

## Requirements
- R1: While reset is asserted, every valid, data, control and error output is zero. Every lane's running disparity starts negative, so the first character after reset must be the negative-disparity form.
- R2: Lane L presents a 10-bit code on bits [10L+9:10L] of the code input, with bit 9 transmitted first. Bits 9:4 form the 6-bit sub-block and bits 3:0 form the 4-bit sub-block. The decoded byte puts the 3-bit value in bits 7:5 and the 5-bit value in bits 4:0.
- R3: Core p serves lanes 2p and 2p+1. It yields at most one result per cycle, so those two lanes are never valid in the same cycle.
- R4: With extend low, lanes with an even index are decoded in cycles where the phase is 1, and odd lanes in cycles where it is 0. The phase is 0 in the first cycle after reset release and toggles every cycle. A result is visible one cycle after its decode cycle.
- R5: With extend high, the schedule is reversed: even lanes are decoded when the phase is 0 and odd lanes when it is 1.
- R6: Each character is held for two cycles, starting in a phase-0 cycle. It then yields exactly one result on its lane, in arrival order, and the valid strobe lasts one cycle.
- R7: Every data byte, encoded with correct disparity, decodes to its value with the control and error flags low.
- R8: The comma character (0011111010 at negative disparity, 1100000101 at positive) yields data 0xBC with the control flag high. It inverts the lane's running disparity.
- R9: Running disparity is kept per lane. Lanes with unrelated histories decode without errors even though they share a core.
- R10: The error flag is set, with data 0x00 and the control flag low, in three cases: a sub-block code outside the table, a non-neutral sub-block whose sign matches the current running disparity, or a K28 prefix that is not followed by the comma's 4-bit code.
- R11: When a lane's valid is low, its data, control and error outputs hold their last values.
- R12: The cycle right after reset release produces no result, because the buffers hold no character yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| extend | input | 1 | Reverses the decode schedule of every pair |
| lane_code | input | 10*NUM_LANES | Received 10-bit codes, lane L at bits [10L+9:10L] |
| lane_data | output | 8*NUM_LANES | Decoded bytes, lane L at bits [8L+7:8L] |
| lane_k | output | NUM_LANES | Control-character flag per lane |
| lane_err | output | NUM_LANES | Code-error flag per lane |
| lane_valid | output | NUM_LANES | One-cycle result strobe per lane |

## Verification
The bench builds the block with the default NUM_PAIRS of 2. This gives four lanes and two independent cores, so both the within-pair alternation and the lockstep of the two cores can be observed. Each lane streams a byte sequence that covers all 256 values, with comma characters mixed in at different rates on different lanes. This gives every lane its own disparity history through a shared core, under both settings of extend. A final run drives an illegal code, a wrong-disparity code and a bad K28 suffix on separate lanes.

// File: rtl/tdm_dec_pkg.sv
package tdm_dec_pkg;
  localparam int CODE_W = 10;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              k;
    logic              err;
  } dec_out_t;
endpackage

// File: rtl/tdm_dec_core.sv
module tdm_dec_core
  import tdm_dec_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              rd_in,
  output dec_out_t          res,
  output logic              rd_out
);
  logic [5:0] six;
  logic [3:0] four;
  logic [4:0] five_val;
  logic [2:0] three_val;
  logic       six_ok, four_ok, is_k28, k_ok, rd_mid, bad_rd, err;
  logic [2:0] six_w, four_w;

  assign six  = code[9:4];
  assign four = code[3:0];

  always_comb begin
    six_ok = 1'b1;
    unique case (six)
      6'b100111, 6'b011000: five_val = 5'd0;
      6'b011101, 6'b100010: five_val = 5'd1;
      6'b101101, 6'b010010: five_val = 5'd2;
      6'b110001:            five_val = 5'd3;
      6'b110101, 6'b001010: five_val = 5'd4;
      6'b101001:            five_val = 5'd5;
      6'b011001:            five_val = 5'd6;
      6'b111000, 6'b000111: five_val = 5'd7;
      6'b111001, 6'b000110: five_val = 5'd8;
      6'b100101:            five_val = 5'd9;
      6'b010101:            five_val = 5'd10;
      6'b110100:            five_val = 5'd11;
      6'b001101:            five_val = 5'd12;
      6'b101100:            five_val = 5'd13;
      6'b011100:            five_val = 5'd14;
      6'b010111, 6'b101000: five_val = 5'd15;
      6'b011011, 6'b100100: five_val = 5'd16;
      6'b100011:            five_val = 5'd17;
      6'b010011:            five_val = 5'd18;
      6'b110010:            five_val = 5'd19;
      6'b001011:            five_val = 5'd20;
      6'b101010:            five_val = 5'd21;
      6'b011010:            five_val = 5'd22;
      6'b111010, 6'b000101: five_val = 5'd23;
      6'b110011, 6'b001100: five_val = 5'd24;
      6'b100110:            five_val = 5'd25;
      6'b010110:            five_val = 5'd26;
      6'b110110, 6'b001001: five_val = 5'd27;
      6'b001110:            five_val = 5'd28;
      6'b101110, 6'b010001: five_val = 5'd29;
      6'b011110, 6'b100001: five_val = 5'd30;
      6'b101011, 6'b010100: five_val = 5'd31;
      default: begin
        five_val = 5'd0;
        six_ok   = 1'b0;
      end
    endcase
  end

  always_comb begin
    four_ok = 1'b1;
    unique case (four)
      4'b1011, 4'b0100:                   three_val = 3'd0;
      4'b1001:                            three_val = 3'd1;
      4'b0101:                            three_val = 3'd2;
      4'b1100, 4'b0011:                   three_val = 3'd3;
      4'b1101, 4'b0010:                   three_val = 3'd4;
      4'b1010:                            three_val = 3'd5;
      4'b0110:                            three_val = 3'd6;
      4'b1110, 4'b0001, 4'b0111, 4'b1000: three_val = 3'd7;
      default: begin
        three_val = 3'd0;
        four_ok   = 1'b0;
      end
    endcase
  end

  always_comb begin
    six_w  = 3'($countones(six));
    four_w = 3'($countones(four));
    is_k28 = (six == 6'b001111) || (six == 6'b110000);
    k_ok   = (six == 6'b001111 && four == 4'b1010) ||
             (six == 6'b110000 && four == 4'b0101);
    rd_mid = (six_w == 3'd4) ? 1'b1 : (six_w == 3'd2) ? 1'b0 : rd_in;
    rd_out = (four_w == 3'd3) ? 1'b1 : (four_w == 3'd1) ? 1'b0 : rd_mid;
    bad_rd = (six_w == 3'd4 && rd_in)   || (six_w == 3'd2 && !rd_in) ||
             (four_w == 3'd3 && rd_mid) || (four_w == 3'd1 && !rd_mid);
    err    = bad_rd || !four_ok || (is_k28 ? !k_ok : !six_ok);
    res.err  = err;
    res.k    = is_k28 && !err;
    res.data = err ? '0 : (is_k28 ? COMMA_BYTE : {three_val, five_val});
  end
endmodule

// File: rtl/tdm_sched.sv
module tdm_sched (
  input  logic clk,
  input  logic rst_n,
  input  logic extend,
  output logic pick_even,
  output logic armed
);
  logic phase_q, phase_n, armed_q, armed_n;

  always_comb begin
    phase_n = ~phase_q;
    armed_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      armed_q <= armed_n;
    end
  end

  assign pick_even = phase_q ^ extend;
  assign armed     = armed_q;

  // R4 R5
  sched_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $stable(extend) |-> pick_even != $past(pick_even));
endmodule

// File: rtl/tdm_pair_dec.sv
module tdm_pair_dec
  import tdm_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              pick_a,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output dec_out_t          res_a,
  output dec_out_t          res_b,
  output logic              vld_a,
  output logic              vld_b
);
  logic [CODE_W-1:0] hold_a_q, hold_b_q, cur_code;
  logic              rd_a_q, rd_b_q, rd_a_n, rd_b_n, cur_rd, new_rd;
  logic              vld_a_q, vld_b_q, vld_a_n, vld_b_n;
  dec_out_t          res_a_q, res_b_q, res_a_n, res_b_n, cur_res;

  always_comb begin
    cur_code = pick_a ? hold_a_q : hold_b_q;
    cur_rd   = pick_a ? rd_a_q : rd_b_q;
  end

  tdm_dec_core u_core (
    .code   (cur_code),
    .rd_in  (cur_rd),
    .res    (cur_res),
    .rd_out (new_rd)
  );

  always_comb begin
    vld_a_n = armed && pick_a;
    vld_b_n = armed && !pick_a;
    res_a_n = vld_a_n ? cur_res : res_a_q;
    res_b_n = vld_b_n ? cur_res : res_b_q;
    rd_a_n  = vld_a_n ? new_rd : rd_a_q;
    rd_b_n  = vld_b_n ? new_rd : rd_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
      rd_a_q   <= 1'b0;
      rd_b_q   <= 1'b0;
      res_a_q  <= '0;
      res_b_q  <= '0;
      vld_a_q  <= 1'b0;
      vld_b_q  <= 1'b0;
    end else begin
      hold_a_q <= code_a;
      hold_b_q <= code_b;
      rd_a_q   <= rd_a_n;
      rd_b_q   <= rd_b_n;
      res_a_q  <= res_a_n;
      res_b_q  <= res_b_n;
      vld_a_q  <= vld_a_n;
      vld_b_q  <= vld_b_n;
    end
  end

  assign res_a = res_a_q;
  assign res_b = res_b_q;
  assign vld_a = vld_a_q;
  assign vld_b = vld_b_q;

  // R3
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_a_q && vld_b_q));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_a_q |=> !vld_a_q);
  // R11
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_a_q |-> $stable(res_a_q));
  // R11
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_b_q |-> $stable(res_b_q));
  // R10
  k_not_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_a_q.k |-> !res_a_q.err);
endmodule

// File: rtl/tdm_8b10b_rx.sv
module tdm_8b10b_rx
  import tdm_dec_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  localparam int NUM_LANES = 2 * NUM_PAIRS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        extend,
  input  logic [CODE_W*NUM_LANES-1:0] lane_code,
  output logic [BYTE_W*NUM_LANES-1:0] lane_data,
  output logic [NUM_LANES-1:0]        lane_k,
  output logic [NUM_LANES-1:0]        lane_err,
  output logic [NUM_LANES-1:0]        lane_valid
);
  logic pick_even, armed;

  tdm_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .extend    (extend),
    .pick_even (pick_even),
    .armed     (armed)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dec_out_t res_a, res_b;
    logic     vld_a, vld_b;

    tdm_pair_dec u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .armed  (armed),
      .pick_a (pick_even),
      .code_a (lane_code[(2*p)*CODE_W +: CODE_W]),
      .code_b (lane_code[(2*p+1)*CODE_W +: CODE_W]),
      .res_a  (res_a),
      .res_b  (res_b),
      .vld_a  (vld_a),
      .vld_b  (vld_b)
    );

    assign lane_data[(2*p)*BYTE_W +: BYTE_W]   = res_a.data;
    assign lane_data[(2*p+1)*BYTE_W +: BYTE_W] = res_b.data;
    assign lane_k[2*p]       = res_a.k;
    assign lane_k[2*p+1]     = res_b.k;
    assign lane_err[2*p]     = res_a.err;
    assign lane_err[2*p+1]   = res_b.err;
    assign lane_valid[2*p]   = vld_a;
    assign lane_valid[2*p+1] = vld_b;

    // R4 R5
    pair_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[2*p] == lane_valid[0]);
  end
endmodule

// File: tb/tdm_8b10b_rx_test.sv
module tdm_8b10b_rx_test;
  localparam int NL = 4;
  typedef logic [9:0] item_t;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           extend;
  logic [10*NL-1:0] codes;
  logic [8*NL-1:0]  lane_data;
  logic [NL-1:0]    lane_k, lane_err, lane_valid;

  int    tests = 0;
  int    fails = 0;
  int    cyc   = 0;
  bit    quiet = 1'b1;
  logic  rd_m [NL];
  item_t last [NL];
  item_t exp_q [NL][$];

  always #4 clk = ~clk;

  tdm_8b10b_rx #(.NUM_PAIRS(2)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .extend     (extend),
    .lane_code  (codes),
    .lane_data  (lane_data),
    .lane_k     (lane_k),
    .lane_err   (lane_err),
    .lane_valid (lane_valid)
  );

  // 6-bit sub-block, negative running disparity form (R2)
  function automatic logic [5:0] six_tab(input int v);
    case (v)
      0: return 6'b100111;   1: return 6'b011101;   2: return 6'b101101;   3: return 6'b110001;
      4: return 6'b110101;   5: return 6'b101001;   6: return 6'b011001;   7: return 6'b111000;
      8: return 6'b111001;   9: return 6'b100101;  10: return 6'b010101;  11: return 6'b110100;
     12: return 6'b001101;  13: return 6'b101100;  14: return 6'b011100;  15: return 6'b010111;
     16: return 6'b011011;  17: return 6'b100011;  18: return 6'b010011;  19: return 6'b110010;
     20: return 6'b001011;  21: return 6'b101010;  22: return 6'b011010;  23: return 6'b111010;
     24: return 6'b110011;  25: return 6'b100110;  26: return 6'b010110;  27: return 6'b110110;
     28: return 6'b001110;  29: return 6'b101110;  30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_tab(input int v);
    case (v)
      0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
      4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
    endcase
  endfunction

  // returns {new running disparity, code}
  function automatic logic [10:0] enc(input logic [7:0] b, input logic kf, input logic rd);
    logic [5:0] s;
    logic [3:0] f;
    logic       r;
    int         x, y;
    if (kf) return {~rd, rd ? 10'b1100000101 : 10'b0011111010};
    r = rd;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    s = six_tab(x);
    if (r && ($countones(s) != 3 || x == 7)) s = ~s;
    if ($countones(s) != 3) r = ~r;
    if (y == 7 && ((!r && (x == 17 || x == 18 || x == 20)) ||
                   (r && (x == 11 || x == 13 || x == 14)))) f = 4'b0111;
    else f = four_tab(y);
    if (r && ($countones(f) != 2 || y == 3)) f = ~f;
    if ($countones(f) != 2) r = ~r;
    return {r, s, f};
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic do_reset(input logic ext);
    quiet  = 1'b1;
    rst_n  = 1'b0;
    extend = ext;
    codes  = '0;
    for (int l = 0; l < NL; l++) begin
      rd_m[l] = 1'b0;
      last[l] = '0;
      exp_q[l].delete();
    end
    repeat (2) @(posedge clk);
    #2;
    tests++;
    if ({lane_data, lane_k, lane_err, lane_valid} != '0) begin
      fails++;
      $display("FAIL R1 reset outputs: got %h expected 0", {lane_data, lane_k, lane_err, lane_valid});
    end
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    quiet = 1'b0;
  endtask

  // driver: one character per lane, held two cycles (R6)
  task automatic send(input logic [31:0] bytes, input logic [3:0] ks);
    for (int l = 0; l < NL; l++) begin
      logic [10:0] e;
      e = enc(bytes[l*8 +: 8], ks[l], rd_m[l]);
      rd_m[l] = e[10];
      codes[l*10 +: 10] = e[9:0];
      exp_q[l].push_back(ks[l] ? {8'hBC, 2'b10} : {bytes[l*8 +: 8], 2'b00});
    end
    @(posedge clk);
    @(posedge clk);
    #2;
  endtask

  task automatic send_raw(input logic [39:0] raw);
    codes = raw;
    for (int l = 0; l < NL; l++) exp_q[l].push_back({8'h00, 2'b01});
    @(posedge clk);
    @(posedge clk);
    #2;
  endtask

  task automatic end_seg();
    repeat (2) @(posedge clk);
    #2;
    quiet = 1'b1;
    for (int l = 0; l < NL; l++) begin
      tests++;
      if (exp_q[l].size() != 0) begin
        fails++;
        $display("FAIL R6 lane %0d results missing: got %0d left, expected 0", l, exp_q[l].size());
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc = 0;
    else cyc++;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !quiet) begin
      if (cyc == 1) begin
        tests++;
        if (lane_valid != '0) begin
          fails++;
          $display("FAIL R12 first cycle result: got %b expected 0000", lane_valid);
        end
      end
      for (int p = 0; p < NL / 2; p++) begin
        tests++;
        if (lane_valid[2*p] && lane_valid[2*p+1]) begin
          fails++;
          $display("FAIL R3 pair %0d both valid: got 11 expected at most one", p);
        end
      end
      for (int l = 0; l < NL; l++) begin
        item_t got, exp;
        int    want_par;
        got = {lane_data[l*8 +: 8], lane_k[l], lane_err[l]};
        if (lane_valid[l]) begin
          tests++;
          if (exp_q[l].size() == 0) begin
            fails++;
            $display("FAIL R6 lane %0d extra result: got %h expected none", l, got);
          end else begin
            exp = exp_q[l].pop_front();
            if (got != exp) begin
              fails++;
              $display("FAIL %s lane %0d: got %h expected %h", exp[0] ? "R10" : (exp[1] ? "R8" : "R7/R9"), l, got, exp);
            end
          end
          tests++;
          want_par = (l & 1) ^ int'(extend);
          if ((cyc & 1) != want_par) begin
            fails++;
            $display("FAIL %s lane %0d result cycle parity: got %0d expected %0d", extend ? "R5" : "R4", l, cyc & 1, want_par);
          end
          last[l] = got;
        end else if (got != last[l]) begin
          tests++;
          fails++;
          $display("FAIL R11 lane %0d changed without valid: got %h expected %h", l, got, last[l]);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R4 R7 R8 R9: extend low, every byte per lane, commas at lane-specific rates
    do_reset(1'b0);
    for (int n = 0; n < 256; n++) begin
      logic [31:0] b;
      logic [3:0]  k;
      for (int l = 0; l < NL; l++) b[l*8 +: 8] = 8'((n + 64 * l) % 256);
      k = {1'b0, (n % 5 == 1), 1'b0, (n % 3 == 0)};
      send(b, k);
    end
    end_seg();

    // R5 R9: extend high, other streams
    do_reset(1'b1);
    for (int n = 0; n < 256; n++) begin
      logic [31:0] b;
      logic [3:0]  k;
      for (int l = 0; l < NL; l++) b[l*8 +: 8] = 8'((n * 7 + 13 * l) % 256);
      k = {(n % 6 == 0), 1'b0, (n % 4 == 2), 1'b0};
      send(b, k);
    end
    end_seg();

    // R10: lane3 bad 6b, lane2 wrong disparity, lane1 bad K28 suffix, lane0 all-zero
    do_reset(1'b0);
    send_raw({10'b1111001010, 10'b0110000100, 10'b0011111001, 10'b0000000000});
    end_seg();

    summary();
    $finish;
  end
endmodule